// File: doc/BRIEF.md
# Conditional Data-Processing Execute Unit

This block is the execute stage for 32-bit register-to-register arithmetic and logic instructions. It retires at most one instruction per clock against a 16-entry general register file and a status word that holds four condition flags and a sticky saturation bit. Every instruction carries a 4-bit predicate. The predicate is tested against the current flags, and a failed predicate turns the instruction into a bubble.

The second operand comes from one of three forms: an 8-bit constant rotated right by an even amount, a register shifted by a constant, or a register shifted by an amount read from a third register. The unit supports bitwise AND, exclusive OR, addition, addition with carry-in and move. When the set-flags bit is present it updates the flags. Add-with-carry uses the stored carry, so a wide sum is built from a sequence of 32-bit additions.

A load port, which a neighbouring pipeline stage uses for memory results, writes the register file and the status word. A combinational read port exposes any register.

Top module: `dp_exec_unit`

## Requirements
- R1: After rst_ni is asserted, every register reads 0 and status_o is 0.
- R2: The predicate is instr_i[31:28]. Each code passes on these flags: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V), 14 always. status_o holds N in bit 31, Z in bit 30, C in bit 29, V in bit 28 and the saturation bit Q in bit 27. All other bits read 0.
- R3: A failed predicate leaves all registers and flags unchanged. Code 15 never passes.
- R4: When instr_i[25]=1, the operand is instr_i[7:0] zero-extended and rotated right by 2*instr_i[11:8]. The shifter carry is the old C when the rotation is 0, and result bit 31 otherwise.
- R5: When instr_i[25]=0 and instr_i[4]=0, Rm=instr_i[3:0] is shifted by instr_i[11:7]. The shift kind is instr_i[6:5]: 0 LSL, 1 LSR, 2 ASR, 3 ROR. A zero amount means: LSL passes Rm and keeps C; LSR and ASR shift by 32; ROR rotates right by one through C.
- R6: When instr_i[25]=0 and instr_i[4]=1, the amount is bits 7:0 of register instr_i[11:8]. Amount 0 passes Rm and keeps C. LSL or LSR by 32 gives 0 with carry Rm[0] or Rm[31]; amounts above 32 give 0 with carry 0. ASR by 32 or more fills with the sign bit. ROR uses the low 5 bits of the amount.
- R7: The opcode is instr_i[24:21]: 0 AND, 1 EOR, 4 ADD, 5 ADC (Rn+op2+C), 13 MOV. Rn is instr_i[19:16] and Rd is instr_i[15:12]. The result is visible on the read port in the cycle after the issuing edge.
- R8: With instr_i[20]=1, ADD and ADC set N to result bit 31, Z to result==0, C to the carry out of bit 31, and V to the signed overflow.
- R9: With instr_i[20]=1, AND, EOR and MOV set N and Z from the result, set C to the shifter carry, and keep V.
- R10: With instr_i[20]=0, an executed instruction leaves the flags unchanged.
- R11: An opcode outside R7, or instr_i[27:26] other than 0, has no effect. exec_o is 1 only for instructions that execute.
- R12: ld_en_i writes ld_data_i to register ld_addr_i. An executing instruction that writes the same register in the same cycle takes priority over the load. psr_ld_i loads {N,Z,C,V,Q} from psr_data_i[4:0], and a flag-setting instruction in the same cycle takes priority for NZCV. Q changes only through psr_ld_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | An instruction is presented this cycle |
| instr_i | input | 32 | Instruction word |
| ld_en_i | input | 1 | Register load strobe |
| ld_addr_i | input | 4 | Register load index |
| ld_data_i | input | 32 | Register load value |
| psr_ld_i | input | 1 | Status load strobe |
| psr_data_i | input | 5 | Status load value {N,Z,C,V,Q} |
| rd_addr_i | input | 4 | Read port index |
| rd_data_o | output | 32 | Read port value (combinational) |
| status_o | output | 32 | Status word |
| exec_o | output | 1 | Presented instruction executes this cycle |

## Verification
The bench builds the unit with its default parameters: a 32-bit datapath and 16 registers. With these values all sixteen register indices are reachable, and the register-controlled amount covers its full byte range. That byte range is what exercises the boundaries at exactly 32, just above 32, and rotate amounts that wrap modulo 32. The 32-bit width also places the overflow and carry boundaries at 0x7FFFFFFF and 0xFFFFFFFF. The bench sweeps every predicate against every flag combination.

// File: rtl/dpx_pkg.sv
package dpx_pkg;

  localparam logic [3:0] OP_AND = 4'b0000;
  localparam logic [3:0] OP_EOR = 4'b0001;
  localparam logic [3:0] OP_ADD = 4'b0100;
  localparam logic [3:0] OP_ADC = 4'b0101;
  localparam logic [3:0] OP_MOV = 4'b1101;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  typedef struct packed {
    logic [3:0]  cond;
    logic [1:0]  cls;
    logic        imm_sel;
    logic [3:0]  opcode;
    logic        set_flags;
    logic [3:0]  rn;
    logic [3:0]  rd;
    logic [3:0]  rot_or_rs;
    logic [4:0]  sh_imm;
    shift_kind_e sh_kind;
    logic        sh_by_reg;
    logic [3:0]  rm;
  } dp_word_t;

  function automatic dp_word_t split_word(input logic [31:0] w);
    dp_word_t f;
    f.cond      = w[31:28];
    f.cls       = w[27:26];
    f.imm_sel   = w[25];
    f.opcode    = w[24:21];
    f.set_flags = w[20];
    f.rn        = w[19:16];
    f.rd        = w[15:12];
    f.rot_or_rs = w[11:8];
    f.sh_imm    = w[11:7];
    f.sh_kind   = shift_kind_e'(w[6:5]);
    f.sh_by_reg = w[4];
    f.rm        = w[3:0];
    return f;
  endfunction

  function automatic logic [7:0] low_byte(input logic [31:0] v);
    return v[7:0];
  endfunction

endpackage

// File: rtl/dpx_cond_eval.sv
module dpx_cond_eval
  import dpx_pkg::*;
(
  input  logic [3:0] cond_i,
  input  flags_t     flags_i,
  output logic       pass_o
);
  logic ge;
  assign ge = (flags_i.n == flags_i.v);

  always_comb begin
    unique case (cond_i)
      4'h0: pass_o = flags_i.z;
      4'h1: pass_o = !flags_i.z;
      4'h2: pass_o = flags_i.c;
      4'h3: pass_o = !flags_i.c;
      4'h4: pass_o = flags_i.n;
      4'h5: pass_o = !flags_i.n;
      4'h6: pass_o = flags_i.v;
      4'h7: pass_o = !flags_i.v;
      4'h8: pass_o = flags_i.c && !flags_i.z;
      4'h9: pass_o = !flags_i.c || flags_i.z;
      4'hA: pass_o = ge;
      4'hB: pass_o = !ge;
      4'hC: pass_o = !flags_i.z && ge;
      4'hD: pass_o = flags_i.z || !ge;
      4'hE: pass_o = 1'b1;
      default: pass_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/dpx_shifter.sv
module dpx_shifter
  import dpx_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] value_i,
  input  logic [7:0]    amount_i,
  input  shift_kind_e   kind_i,
  input  logic          rrx_i,
  input  logic          carry_i,
  output logic [DW-1:0] result_o,
  output logic          carry_o
);
  localparam int RW = $clog2(DW);
  localparam logic [7:0] FULL = 8'(DW);

  logic [DW:0]        lsl_w, lsr_w;
  logic signed [DW:0] asr_w;
  logic [7:0]         asr_amt;
  logic [RW-1:0]      rot;
  logic [DW-1:0]      ror_w;

  always_comb begin
    lsl_w   = {1'b0, value_i} << amount_i;
    lsr_w   = {value_i, 1'b0} >> amount_i;
    asr_amt = (amount_i > FULL) ? FULL : amount_i;
    asr_w   = $signed({value_i, 1'b0}) >>> asr_amt;
    rot     = amount_i[RW-1:0];
    ror_w   = (value_i >> rot) | (value_i << (DW - int'(rot)));

    if (rrx_i) begin
      result_o = {carry_i, value_i[DW-1:1]};
      carry_o  = value_i[0];
    end else if (amount_i == 8'd0) begin
      result_o = value_i;
      carry_o  = carry_i;
    end else begin
      unique case (kind_i)
        SH_LSL: begin result_o = lsl_w[DW-1:0]; carry_o = lsl_w[DW]; end
        SH_LSR: begin result_o = lsr_w[DW:1];   carry_o = lsr_w[0];  end
        SH_ASR: begin result_o = asr_w[DW:1];   carry_o = asr_w[0];  end
        default: begin result_o = ror_w;        carry_o = ror_w[DW-1]; end
      endcase
    end
  end
endmodule

// File: rtl/dpx_alu.sv
module dpx_alu
  import dpx_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  flags_t        flags_i,
  input  logic          sh_carry_i,
  output logic [DW-1:0] result_o,
  output flags_t        flags_o,
  output logic          known_o
);
  logic [DW:0] sum;
  logic        cin;

  always_comb begin
    cin      = (op_i == OP_ADC) ? flags_i.c : 1'b0;
    sum      = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, cin};
    known_o  = 1'b1;
    flags_o  = flags_i;
    result_o = '0;
    unique case (op_i)
      OP_AND: result_o = a_i & b_i;
      OP_EOR: result_o = a_i ^ b_i;
      OP_MOV: result_o = b_i;
      OP_ADD, OP_ADC: result_o = sum[DW-1:0];
      default: known_o = 1'b0;
    endcase
    flags_o.n = result_o[DW-1];
    flags_o.z = (result_o == '0);
    if (op_i == OP_ADD || op_i == OP_ADC) begin
      flags_o.c = sum[DW];
      flags_o.v = (a_i[DW-1] == b_i[DW-1]) && (sum[DW-1] != a_i[DW-1]);
    end else begin
      flags_o.c = sh_carry_i;
    end
  end
endmodule

// File: rtl/dpx_regfile.sv
module dpx_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 16,
  parameter int NRD  = 4,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_hi_i,
  input  logic [AW-1:0]           addr_hi_i,
  input  logic [DW-1:0]           data_hi_i,
  input  logic                    we_lo_i,
  input  logic [AW-1:0]           addr_lo_i,
  input  logic [DW-1:0]           data_lo_i,
  input  logic [NRD-1:0][AW-1:0]  raddr_i,
  output logic [NRD-1:0][DW-1:0]  rdata_o
);
  logic [NREG-1:0][DW-1:0] regs_q;

  for (genvar g = 0; g < NREG; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_q[g] <= '0;
      end else if (we_hi_i && addr_hi_i == AW'(g)) begin
        regs_q[g] <= data_hi_i;
      end else if (we_lo_i && addr_lo_i == AW'(g)) begin
        regs_q[g] <= data_lo_i;
      end
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rport
    assign rdata_o[p] = regs_q[raddr_i[p]];
  end
endmodule

// File: rtl/dp_exec_unit.sv
module dp_exec_unit
  import dpx_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NREG = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    instr_valid_i,
  input  logic [31:0]             instr_i,
  input  logic                    ld_en_i,
  input  logic [$clog2(NREG)-1:0] ld_addr_i,
  input  logic [DW-1:0]           ld_data_i,
  input  logic                    psr_ld_i,
  input  logic [4:0]              psr_data_i,
  input  logic [$clog2(NREG)-1:0] rd_addr_i,
  output logic [DW-1:0]           rd_data_o,
  output logic [31:0]             status_o,
  output logic                    exec_o
);
  localparam int AW  = $clog2(NREG);
  localparam int NRD = 4;
  localparam int P_RN = 0, P_RM = 1, P_RS = 2, P_EXT = 3;

  dp_word_t f;
  flags_t   flags_q, alu_flags;
  logic     q_q;

  logic [NRD-1:0][AW-1:0] raddr;
  logic [NRD-1:0][DW-1:0] rdata;

  logic          cond_pass, op_known;
  logic [DW-1:0] sh_in, sh_out, alu_res;
  logic [7:0]    sh_amt;
  shift_kind_e   sh_kind;
  logic          sh_rrx, sh_carry;

  assign f = split_word(instr_i);

  assign raddr[P_RN]  = AW'(f.rn);
  assign raddr[P_RM]  = AW'(f.rm);
  assign raddr[P_RS]  = AW'(f.rot_or_rs);
  assign raddr[P_EXT] = rd_addr_i;
  assign rd_data_o    = rdata[P_EXT];

  dpx_regfile #(.DW(DW), .NREG(NREG), .NRD(NRD)) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_hi_i  (exec_o),
    .addr_hi_i(AW'(f.rd)),
    .data_hi_i(alu_res),
    .we_lo_i  (ld_en_i),
    .addr_lo_i(ld_addr_i),
    .data_lo_i(ld_data_i),
    .raddr_i  (raddr),
    .rdata_o  (rdata)
  );

  dpx_cond_eval i_cond (
    .cond_i (f.cond),
    .flags_i(flags_q),
    .pass_o (cond_pass)
  );

  // Operand-2 source select
  always_comb begin
    sh_rrx  = 1'b0;
    sh_kind = f.sh_kind;
    if (f.imm_sel) begin
      sh_in   = DW'(instr_i[7:0]);
      sh_amt  = {3'b000, f.rot_or_rs, 1'b0};
      sh_kind = SH_ROR;
    end else if (f.sh_by_reg) begin
      sh_in  = rdata[P_RM];
      sh_amt = low_byte(rdata[P_RS]);
    end else begin
      sh_in  = rdata[P_RM];
      sh_amt = {3'b000, f.sh_imm};
      if (f.sh_imm == 5'd0) begin
        unique case (f.sh_kind)
          SH_LSR, SH_ASR: sh_amt = 8'(DW);
          SH_ROR:         sh_rrx = 1'b1;
          default:        sh_amt = 8'd0;
        endcase
      end
    end
  end

  dpx_shifter #(.DW(DW)) i_shift (
    .value_i (sh_in),
    .amount_i(sh_amt),
    .kind_i  (sh_kind),
    .rrx_i   (sh_rrx),
    .carry_i (flags_q.c),
    .result_o(sh_out),
    .carry_o (sh_carry)
  );

  dpx_alu #(.DW(DW)) i_alu (
    .op_i      (f.opcode),
    .a_i       (rdata[P_RN]),
    .b_i       (sh_out),
    .flags_i   (flags_q),
    .sh_carry_i(sh_carry),
    .result_o  (alu_res),
    .flags_o   (alu_flags),
    .known_o   (op_known)
  );

  assign exec_o = instr_valid_i && cond_pass && op_known && (f.cls == 2'b00);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      q_q     <= 1'b0;
    end else begin
      if (exec_o && f.set_flags) flags_q <= alu_flags;
      else if (psr_ld_i)         flags_q <= flags_t'(psr_data_i[4:1]);
      if (psr_ld_i)              q_q     <= psr_data_i[0];
    end
  end

  assign status_o = {flags_q, q_q, 27'd0};
endmodule

// File: rtl/dp_exec_unit_chk.sv
module dp_exec_unit_chk #(
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          instr_valid_i,
  input logic [31:0]   instr_i,
  input logic          psr_ld_i,
  input logic [31:0]   status_o,
  input logic          exec_o,
  input logic          cond_pass,
  input logic [DW-1:0] alu_res
);
  logic is_logic_op;
  assign is_logic_op = (instr_i[24:21] == 4'b0000) || (instr_i[24:21] == 4'b0001) ||
                       (instr_i[24:21] == 4'b1101);

  p_always_code_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && instr_i[31:28] == 4'hE |-> cond_pass);

  p_never_code_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && instr_i[31:28] == 4'hF |-> !exec_o);

  p_skip_keeps_flags_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && !exec_o && !psr_ld_i |=> $stable(status_o));

  p_nz_from_result_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o && instr_i[20] |=> status_o[31] == $past(alu_res[DW-1]) &&
                              status_o[30] == ($past(alu_res) == '0));

  p_logic_keeps_v_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o && instr_i[20] && is_logic_op |=> status_o[28] == $past(status_o[28]));

  p_no_s_keeps_flags_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_valid_i && !instr_i[20] && !psr_ld_i |=> $stable(status_o));

  p_q_only_by_load_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !psr_ld_i |=> $stable(status_o[27]));

  p_low_status_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[26:0] == 27'd0);
endmodule

bind dp_exec_unit dp_exec_unit_chk #(.DW(DW)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .instr_valid_i(instr_valid_i),
  .instr_i      (instr_i),
  .psr_ld_i     (psr_ld_i),
  .status_o     (status_o),
  .exec_o       (exec_o),
  .cond_pass    (cond_pass),
  .alu_res      (alu_res)
);

// File: tb/test_dp_exec_unit.sv
`timescale 1ns/1ps
module test_dp_exec_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        instr_valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic        ld_en_i = 1'b0;
  logic [3:0]  ld_addr_i = '0;
  logic [31:0] ld_data_i = '0;
  logic        psr_ld_i = 1'b0;
  logic [4:0]  psr_data_i = '0;
  logic [3:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o, status_o;
  logic        exec_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  dp_exec_unit i_dp_exec_unit (
    .clk_i(clk), .rst_ni(rst_ni), .instr_valid_i(instr_valid_i), .instr_i(instr_i),
    .ld_en_i(ld_en_i), .ld_addr_i(ld_addr_i), .ld_data_i(ld_data_i),
    .psr_ld_i(psr_ld_i), .psr_data_i(psr_data_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .status_o(status_o), .exec_o(exec_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic load_reg(input int a, input logic [31:0] d);
    @(negedge clk);
    ld_en_i = 1'b1; ld_addr_i = 4'(a); ld_data_i = d;
    @(negedge clk);
    ld_en_i = 1'b0;
  endtask

  // p = {N,Z,C,V,Q}
  task automatic load_psr(input logic [4:0] p);
    @(negedge clk);
    psr_ld_i = 1'b1; psr_data_i = p;
    @(negedge clk);
    psr_ld_i = 1'b0;
  endtask

  task automatic run(input logic [31:0] w);
    @(negedge clk);
    instr_valid_i = 1'b1; instr_i = w;
    @(negedge clk);
    instr_valid_i = 1'b0;
  endtask

  task automatic read_reg(input int a, output logic [31:0] d);
    rd_addr_i = 4'(a);
    #1;
    d = rd_data_o;
  endtask

  task automatic expect_reg(input string req, input int a, input logic [31:0] exp);
    logic [31:0] d;
    read_reg(a, d);
    check(req, d, exp);
  endtask

  task automatic expect_nzcv(input string req, input logic [3:0] exp);
    check(req, {28'd0, status_o[31:28]}, {28'd0, exp});
  endtask

  function automatic bit model_cond(input logic [3:0] c, input logic [3:0] fl);
    bit n = fl[3], z = fl[2], cy = fl[1], v = fl[0];
    case (c)
      4'h0: return z;        4'h1: return !z;
      4'h2: return cy;       4'h3: return !cy;
      4'h4: return n;        4'h5: return !n;
      4'h6: return v;        4'h7: return !v;
      4'h8: return cy && !z; 4'h9: return !cy || z;
      4'hA: return n == v;   4'hB: return n != v;
      4'hC: return !z && (n == v);
      4'hD: return z || (n != v);
      4'hE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic t_reset;
    for (int a = 0; a < 16; a++) expect_reg("R1 reg zero", a, 32'h0);
    check("R1 status zero", status_o, 32'h0);
  endtask

  task automatic t_imm_rotate;
    load_reg(1, 32'd3);
    run(32'hE2810A01);
    expect_reg("R4 imm rot 0x1000", 0, 32'h0000_1003);
    load_psr(5'b00000);
    run(32'hE3A004FF);
    expect_reg("R4 imm rot 8", 0, 32'hFF00_0000);
    run(32'hE3B004FF);
    expect_nzcv("R4 rot carry", 4'b1010);
  endtask

  task automatic t_logic_ops;
    load_reg(0, 32'd3);
    run(32'hE220001E);
    expect_reg("R7 EOR", 0, 32'h1D);
    load_reg(0, 32'd3);
    run(32'hE200001E);
    expect_reg("R7 AND", 0, 32'h2);
  endtask

  task automatic t_add_adc;
    load_psr(5'b00100);
    load_reg(9, 32'd3);
    load_reg(10, 32'd1);
    run(32'hE2A9A00F);
    expect_reg("R7 ADC carry in", 10, 32'h13);
    run(32'hE289A00F);
    expect_reg("R7 ADD ignores C", 10, 32'h12);
  endtask

  task automatic t_imm_shift;
    load_psr(5'b00000);
    load_reg(2, 32'd3);
    load_reg(3, 32'd1);
    run(32'hE0A33102);
    expect_reg("R5 LSL #2", 3, 32'hD);
    load_reg(5, 32'h8000_0001);
    load_psr(5'b00010);
    run(32'hE1B070A5);
    expect_reg("R9 LSR #1 value", 7, 32'h4000_0000);
    expect_nzcv("R9 shifter C, V kept", 4'b0011);
    load_psr(5'b00000);
    run(32'hE1B07025);
    expect_reg("R5 LSR #0 as 32", 7, 32'h0);
    expect_nzcv("R5 LSR #0 flags", 4'b0110);
    load_psr(5'b00000);
    run(32'hE1B07045);
    expect_reg("R5 ASR #0 as 32", 7, 32'hFFFF_FFFF);
    expect_nzcv("R5 ASR #0 flags", 4'b1010);
    load_psr(5'b00000);
    run(32'hE1B07065);
    expect_reg("R5 RRX C=0", 7, 32'h4000_0000);
    expect_nzcv("R5 RRX flags", 4'b0010);
    load_psr(5'b00100);
    run(32'hE1B07065);
    expect_reg("R5 RRX C=1", 7, 32'hC000_0000);
  endtask

  task automatic t_reg_shift;
    load_psr(5'b00100);
    load_reg(4, 32'd1);
    load_reg(5, 32'h4000_0000);
    load_reg(6, 32'd1);
    run(32'hE0A66415);
    expect_reg("R6 ADC LSL by reg", 6, 32'h8000_0002);
    load_reg(5, 32'h8000_0001);
    load_reg(4, 32'd32);
    load_psr(5'b00000);
    run(32'hE1B07415);
    expect_reg("R6 LSL by 32", 7, 32'h0);
    expect_nzcv("R6 LSL 32 carry", 4'b0110);
    load_reg(4, 32'd33);
    run(32'hE1B07415);
    expect_nzcv("R6 LSL 33 carry", 4'b0100);
    load_reg(4, 32'd0);
    load_psr(5'b00100);
    run(32'hE1B07415);
    expect_reg("R6 amount 0 value", 7, 32'h8000_0001);
    expect_nzcv("R6 amount 0 keeps C", 4'b1010);
    load_reg(4, 32'h0000_0120);
    load_psr(5'b00000);
    run(32'hE1B07435);
    expect_reg("R6 LSR low byte 32", 7, 32'h0);
    expect_nzcv("R6 LSR 32 carry", 4'b0110);
    load_reg(4, 32'd36);
    run(32'hE1B07475);
    expect_reg("R6 ROR mod 32", 7, 32'h1800_0000);
    expect_nzcv("R6 ROR carry", 4'b0000);
  endtask

  task automatic t_arith_flags;
    load_psr(5'b00000);
    load_reg(1, 32'h7FFF_FFFF);
    run(32'hE2910001);
    expect_reg("R8 overflow value", 0, 32'h8000_0000);
    expect_nzcv("R8 overflow flags", 4'b1001);
    load_psr(5'b00000);
    load_reg(1, 32'hFFFF_FFFF);
    run(32'hE2910001);
    expect_reg("R8 low word", 0, 32'h0);
    expect_nzcv("R8 carry out", 4'b0110);
    load_reg(1, 32'h0);
    run(32'hE2B10001);
    expect_reg("R8 chained high word", 0, 32'h2);
    expect_nzcv("R8 chained flags", 4'b0000);
  endtask

  task automatic t_no_s;
    load_psr(5'b01010);
    load_reg(1, 32'h7FFF_FFFF);
    run(32'hE2810001);
    expect_reg("R10 value", 0, 32'h8000_0000);
    expect_nzcv("R10 flags kept", 4'b0101);
  endtask

  task automatic t_unsupported;
    load_psr(5'b00000);
    load_reg(0, 32'h1234);
    load_reg(1, 32'h5);
    run(32'hE2510001);
    expect_reg("R11 other opcode reg", 0, 32'h1234);
    check("R11 other opcode status", status_o, 32'h0);
    run(32'hE7B00001);
    expect_reg("R11 other class reg", 0, 32'h1234);
    check("R11 other class status", status_o, 32'h0);
    @(negedge clk);
    instr_valid_i = 1'b1; instr_i = 32'hE2510001;
    #1;
    check("R11 exec_o low", {31'd0, exec_o}, 32'h0);
    instr_i = 32'hE3A00001;
    #1;
    check("R11 exec_o high", {31'd0, exec_o}, 32'h1);
    @(negedge clk);
    instr_valid_i = 1'b0;
  endtask

  task automatic t_ports;
    @(negedge clk);
    ld_en_i = 1'b1; ld_addr_i = 4'd0; ld_data_i = 32'h55;
    instr_valid_i = 1'b1; instr_i = 32'hE3A00001;
    @(negedge clk);
    ld_en_i = 1'b0; instr_valid_i = 1'b0;
    expect_reg("R12 instr beats load", 0, 32'h1);
    load_reg(1, 32'd1);
    @(negedge clk);
    psr_ld_i = 1'b1; psr_data_i = 5'b11111;
    instr_valid_i = 1'b1; instr_i = 32'hE2910001;
    @(negedge clk);
    psr_ld_i = 1'b0; instr_valid_i = 1'b0;
    check("R12 flags beat load, Q loaded", status_o, 32'h0800_0000);
    run(32'hE2910001);
    check("R12 Q kept by ADDS", status_o, 32'h0800_0000);
    load_reg(11, 32'hCAFE_F00D);
    expect_reg("R12 load port", 11, 32'hCAFE_F00D);
  endtask

  task automatic t_conditions;
    for (int c = 0; c < 16; c++) begin
      for (int fl = 0; fl < 16; fl++) begin
        load_reg(0, 32'h0);
        load_psr({4'(fl), 1'b0});
        run({4'(c), 28'h3A000FF});
        expect_reg($sformatf("R2 R3 code %0d flags %0h", c, fl), 0,
                   model_cond(4'(c), 4'(fl)) ? 32'hFF : 32'h0);
        expect_nzcv("R3 flags unchanged", 4'(fl));
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_imm_rotate();
    t_logic_ops();
    t_add_adc();
    t_imm_shift();
    t_reg_shift();
    t_arith_flags();
    t_no_s();
    t_unsupported();
    t_ports();
    t_conditions();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule